// File: doc/BRIEF.md
# Reset Handshake Sequencer

This block orders the steps of a platform reset. When a reset request arrives, it first tells the processor, through a one-cycle warning strobe, that a reset is coming. The processor then has a chance to finish its outstanding memory traffic and answer with an acknowledge. Only after that does the block drive the platform reset output.

The processor is not obliged to answer. If the acknowledge does not come within a fixed window, the sequencer does not wait any longer. It escalates to a global reset and asks for a power cycle. The window is a tick count, about four seconds at the default clock, and a test can shorten it. Two kinds of request exist. A host request resets only the host partition. A global request also resets the management partition, which is signalled on a separate output.

The platform reset is held for a minimum number of cycles. It is then released for one cycle, and the block returns to idle. Transport of the messages and the power sequencing itself belong to neighbouring logic.

Top module: `rst_handshake_seq`

## Requirements
- R1: After reset, all four outputs (`warn_stb_o`, `plat_rst_o`, `glob_rst_o`, `pwr_cycle_o`) are low and the sequencer is idle.
- R2: A request sampled while idle raises `warn_stb_o` in the following cycle for exactly one cycle. The platform reset is never high before that strobe.
- R3: After a host request, an acknowledge sampled while waiting raises `plat_rst_o` in the next cycle, with `glob_rst_o` and `pwr_cycle_o` low.
- R4: After a global request, an acknowledge sampled while waiting raises both `plat_rst_o` and `glob_rst_o` in the next cycle, with `pwr_cycle_o` low.
- R5: If no acknowledge is sampled in ACK_TIMEOUT consecutive waiting cycles, then `plat_rst_o`, `glob_rst_o` and `pwr_cycle_o` all rise together in the next cycle. An acknowledge in the last of those cycles still counts as an acknowledge.
- R6: The reset outputs stay high for exactly HOLD_CYCLES cycles. Then all outputs stay low for one release cycle, and after that a new request is accepted.
- R7: An acknowledge has no effect while the sequencer is idle, is sending the warning, or is holding the reset.
- R8: A request has no effect while a sequence is in progress, up to and including the release cycle.
- R9: If a host request and a global request arrive in the same cycle, the sequence is treated as global.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_trig_i | input | 1 | Host-partition reset request |
| glob_trig_i | input | 1 | Global reset request |
| cpu_ack_i | input | 1 | Processor acknowledge of the warning |
| warn_stb_o | output | 1 | One-cycle warning strobe to the processor |
| plat_rst_o | output | 1 | Platform reset, active high |
| glob_rst_o | output | 1 | Management partition is reset as well |
| pwr_cycle_o | output | 1 | Power-cycle request after a missed acknowledge |

## Verification
The hardest case to reach is the race at the end of the acknowledge window. An acknowledge in the final waiting cycle must win over the timeout, while one cycle later the escalation must happen. The stimulus reaches this case by counting clock edges from the warning strobe. It places the acknowledge after exactly ACK_TIMEOUT-1 silent cycles, and in another run it withholds the acknowledge entirely.

Separate runs inject an acknowledge and new requests while the warning is being sent, while the reset is held, and during the release cycle. Those runs show that the sequence timing is unchanged by them.

// File: rtl/rsthsk_pkg.sv
package rsthsk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WARN,
    ST_WAIT_ACK,
    ST_ASSERT_HOST,
    ST_ASSERT_GLOBAL,
    ST_RELEASE
  } seq_state_e;

  // True on the final tick of a window that spans 'limit' cycles.
  function automatic logic at_last_tick(input logic [63:0] cnt, input logic [63:0] limit);
    if (limit <= 64'd1) return 1'b1;
    return cnt == (limit - 64'd1);
  endfunction

  // Width of a counter that must hold values 0 .. limit-1.
  function automatic int cnt_bits(input longint unsigned limit);
    if (limit <= 2) return 1;
    return $clog2(limit);
  endfunction

endpackage

// File: rtl/rsthsk_tick_cnt.sv
module rsthsk_tick_cnt
  import rsthsk_pkg::*;
#(
  parameter longint unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);

  localparam int CW = cnt_bits(LIMIT);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = at_last_tick(64'(cnt_q), 64'(LIMIT));
  assign last_o = run_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || wrap)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  // The window counters (acknowledge timeout R5, hold width R6) stay inside their span.
  assert_cnt_in_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    64'(cnt_q) < 64'(LIMIT) || LIMIT == 0);

  // A stopped counter restarts from zero.
  assert_cnt_idle_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);

endmodule

// File: rtl/rsthsk_fsm.sv
module rsthsk_fsm
  import rsthsk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_trig_i,
  input  logic glob_trig_i,
  input  logic cpu_ack_i,
  input  logic wait_last_i,
  input  logic hold_last_i,
  output logic wait_run_o,
  output logic hold_run_o,
  output logic warn_stb_o,
  output logic plat_rst_o,
  output logic glob_rst_o,
  output logic pwr_cycle_o
);

  seq_state_e state_q, state_d;
  logic       glob_kind_q, glob_kind_d;
  logic       escalated_q, escalated_d;

  // Named events for the assertions
  logic trig_any;
  logic trig_taken;
  logic ack_take;
  logic timeout_hit;

  assign trig_any    = host_trig_i || glob_trig_i;
  assign trig_taken  = (state_q == ST_IDLE) && trig_any;
  assign ack_take    = (state_q == ST_WAIT_ACK) && cpu_ack_i;
  assign timeout_hit = (state_q == ST_WAIT_ACK) && !cpu_ack_i && wait_last_i;

  always_comb begin
    state_d     = state_q;
    glob_kind_d = glob_kind_q;
    escalated_d = escalated_q;
    unique case (state_q)
      ST_IDLE: begin
        if (trig_any) begin
          state_d     = ST_WARN;
          glob_kind_d = glob_trig_i;
          escalated_d = 1'b0;
        end
      end
      ST_WARN:     state_d = ST_WAIT_ACK;
      ST_WAIT_ACK: begin
        if (ack_take) begin
          state_d = glob_kind_q ? ST_ASSERT_GLOBAL : ST_ASSERT_HOST;
        end else if (timeout_hit) begin
          state_d     = ST_ASSERT_GLOBAL;
          escalated_d = 1'b1;
        end
      end
      ST_ASSERT_HOST, ST_ASSERT_GLOBAL: begin
        if (hold_last_i) state_d = ST_RELEASE;
      end
      ST_RELEASE:  state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      glob_kind_q <= 1'b0;
      escalated_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      glob_kind_q <= glob_kind_d;
      escalated_q <= escalated_d;
    end
  end

  assign wait_run_o  = (state_q == ST_WAIT_ACK);
  assign hold_run_o  = (state_q == ST_ASSERT_HOST) || (state_q == ST_ASSERT_GLOBAL);
  assign warn_stb_o  = (state_q == ST_WARN);
  assign plat_rst_o  = hold_run_o;
  assign glob_rst_o  = (state_q == ST_ASSERT_GLOBAL);
  assign pwr_cycle_o = (state_q == ST_ASSERT_GLOBAL) && escalated_q;

  assert_warn_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_stb_o |=> !warn_stb_o);

  assert_warn_after_trig_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_taken |=> warn_stb_o);

  assert_plat_needs_handshake_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(plat_rst_o) |-> $past(ack_take || timeout_hit));

  assert_timeout_escalates_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_hit |=> (pwr_cycle_o && glob_rst_o && plat_rst_o));

  assert_ack_no_power_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_take |=> !pwr_cycle_o);

  assert_idle_ack_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !trig_any) |=> state_q == ST_IDLE);

  assert_busy_trig_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RELEASE) |=> (state_q == ST_IDLE && !warn_stb_o));

  assert_outputs_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({warn_stb_o, plat_rst_o}));

endmodule

// File: rtl/rst_handshake_seq.sv
module rst_handshake_seq
  import rsthsk_pkg::*;
#(
  parameter longint unsigned ACK_TIMEOUT = 400_000_000,
  parameter longint unsigned HOLD_CYCLES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_trig_i,
  input  logic glob_trig_i,
  input  logic cpu_ack_i,
  output logic warn_stb_o,
  output logic plat_rst_o,
  output logic glob_rst_o,
  output logic pwr_cycle_o
);

  logic wait_run, wait_last;
  logic hold_run, hold_last;

  rsthsk_tick_cnt #(.LIMIT(ACK_TIMEOUT)) u_ack_window (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (wait_run),
    .last_o (wait_last)
  );

  rsthsk_tick_cnt #(.LIMIT(HOLD_CYCLES)) u_hold_window (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (hold_run),
    .last_o (hold_last)
  );

  rsthsk_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_trig_i (host_trig_i),
    .glob_trig_i (glob_trig_i),
    .cpu_ack_i   (cpu_ack_i),
    .wait_last_i (wait_last),
    .hold_last_i (hold_last),
    .wait_run_o  (wait_run),
    .hold_run_o  (hold_run),
    .warn_stb_o  (warn_stb_o),
    .plat_rst_o  (plat_rst_o),
    .glob_rst_o  (glob_rst_o),
    .pwr_cycle_o (pwr_cycle_o)
  );

  assert_pwr_implies_global_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_cycle_o |-> (glob_rst_o && plat_rst_o));

  assert_release_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(plat_rst_o) |-> (!plat_rst_o && !warn_stb_o));

endmodule

// File: tb/rst_handshake_seq_tb.sv
`timescale 1ns/1ps
module rst_handshake_seq_tb;

  localparam int TMO  = 6;
  localparam int HOLD = 4;

  // Expected output code: {warn, plat, glob, pwr}
  localparam logic [3:0] E_NONE = 4'b0000;
  localparam logic [3:0] E_WARN = 4'b1000;
  localparam logic [3:0] E_HOST = 4'b0100;
  localparam logic [3:0] E_GLOB = 4'b0110;
  localparam logic [3:0] E_PWR  = 4'b0111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_trig = 1'b0, glob_trig = 1'b0, cpu_ack = 1'b0;
  logic warn, plat, glob, pwr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  rst_handshake_seq #(.ACK_TIMEOUT(TMO), .HOLD_CYCLES(HOLD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_trig_i(host_trig), .glob_trig_i(glob_trig), .cpu_ack_i(cpu_ack),
    .warn_stb_o(warn), .plat_rst_o(plat), .glob_rst_o(glob), .pwr_cycle_o(pwr)
  );

  // Driver: sets inputs for the coming edge and predicts the outputs after it.
  task automatic step(input logic th, input logic tg, input logic ak,
                      input logic [3:0] exp, input string tag);
    @(negedge clk);
    host_trig = th;
    glob_trig = tg;
    cpu_ack   = ak;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares the outputs after each edge with the predicted item.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if ({warn, plat, glob, pwr} !== e) begin
          mismatched++;
          $display("FAIL %s: outputs %b expected %b at %0t", t, {warn, plat, glob, pwr}, e, $time);
        end
      end
    end
  end

  // One full sequence. ack_wait = silent waiting cycles before the acknowledge;
  // ack_wait >= TMO means no acknowledge. noise injects ignored acks and requests.
  task automatic run_seq(input logic th, input logic tg, input int ack_wait, input bit noise);
    logic [3:0] e_on;
    string t_on;
    if (ack_wait >= TMO) begin e_on = E_PWR; t_on = "R5"; end
    else if (tg)         begin e_on = E_GLOB; t_on = (th ? "R9" : "R4"); end
    else                 begin e_on = E_HOST; t_on = "R3"; end
    step(th, tg, 1'b0, E_WARN, "R2");                        // R2 strobe
    step(noise, noise, noise, E_NONE, noise ? "R7" : "R2");  // R7/R8 in WARN, strobe ends
    if (ack_wait >= TMO) begin
      for (int i = 0; i < TMO - 1; i++) step(1'b0, 1'b0, 1'b0, E_NONE, "R5");
      step(1'b0, 1'b0, 1'b0, e_on, "R5");                    // R5 timeout edge
    end else begin
      for (int i = 0; i < ack_wait; i++) step(1'b0, 1'b0, 1'b0, E_NONE, "R3");
      step(1'b0, 1'b0, 1'b1, e_on, t_on);
    end
    for (int i = 0; i < HOLD - 1; i++)
      step(noise, 1'b0, noise, e_on, noise ? "R7" : "R6");   // R6 hold, R7 ack ignored
    step(noise, noise, 1'b0, E_NONE, "R6");                  // R6 release cycle
    step(noise, noise, 1'b0, E_NONE, "R8");                  // R8 request in release ignored
    step(1'b0, 1'b0, noise, E_NONE, "R7");                   // R7 ack while idle
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    compared++;
    if ({warn, plat, glob, pwr} !== E_NONE) begin
      mismatched++;
      $display("FAIL R1: outputs %b expected %b during reset", {warn, plat, glob, pwr}, E_NONE);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    compared++;
    if ({warn, plat, glob, pwr} !== E_NONE) begin
      mismatched++;
      $display("FAIL R1: outputs %b expected %b after reset", {warn, plat, glob, pwr}, E_NONE);
    end

    step(1'b0, 1'b0, 1'b1, E_NONE, "R7");       // R7 ack with nothing pending
    step(1'b0, 1'b0, 1'b0, E_NONE, "R7");
    run_seq(1'b1, 1'b0, 0, 1'b0);               // R3 immediate ack
    run_seq(1'b1, 1'b0, 3, 1'b0);               // R3 late ack
    run_seq(1'b0, 1'b1, 2, 1'b0);               // R4 global with ack
    run_seq(1'b1, 1'b0, TMO - 1, 1'b0);         // R5 ack on last allowed cycle
    run_seq(1'b1, 1'b0, TMO, 1'b0);             // R5 no ack: escalation
    run_seq(1'b0, 1'b1, TMO, 1'b0);             // R5 global request, no ack
    run_seq(1'b1, 1'b1, 1, 1'b0);               // R9 both requests together
    run_seq(1'b1, 1'b0, 2, 1'b1);               // R7/R8 noise during host sequence
    run_seq(1'b0, 1'b1, TMO, 1'b1);             // R7/R8 noise during escalation
    run_seq(1'b1, 1'b0, 0, 1'b0);               // R6 back-to-back restart after release

    wait (exp_q.size() == 0);
    @(posedge clk);
    #3;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule